// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This peripheral holds a 16-bit count, split into two bytes, beside a 16-bit reload/capture value and two control bytes. The host reaches all six through one byte-wide register port. The count advances on a qualified system tick or on falling edges of an external count pin. A second external pin, the trigger pin, serves three purposes. It can snapshot the count. It can force the reload value into the count. In up/down mode it sets the counting direction.

Overflows raise a sticky overflow flag. They can also toggle an output pin. They can serve as baud pulses for a serial receiver or a serial transmitter. While either baud pulse output is selected, the overflow flag is held off and every overflow reloads the count. One interrupt request line combines the two sticky flags. The block has no streaming data path: the register port is a plain single-cycle write strobe with a combinational read mux, so it applies no back-pressure. Both external pins pass through a two-flop synchronizer before edge detection, which adds three clock cycles of latency from pin to effect.

Top module: `cr_timer16`

## Requirements
- R1: After reset every register (addresses 0 to 5) reads 00h, and `irq`, `clk_out`, `rx_baud_pulse` and `tx_baud_pulse` are low.
- R2: The register map is 0 = count low, 1 = count high, 2 = reload low, 3 = reload high, 4 = control and 5 = mode. The control bits, from bit 7 down to bit 0, are ovf_flag, ext_flag, rx_sel, tx_sel, ext_en, run, src_ext and cap_mode. The mode bits are bit 1 = pin_out_en and bit 0 = updown_en, and mode bits 7 to 2 read 0.
- R3: With run=1 and src_ext=0, the count goes up by one on each cycle in which `tick_in` is high. With run=0 the count holds.
- R4: With src_ext=1, the count advances once per synchronized falling edge of `count_pin`, and `tick_in` has no effect.
- R5: Counting up from FFFFh is an overflow and sets ovf_flag. After it the count is 0000h when cap_mode=1, and the reload value when cap_mode=0.
- R6: ovf_flag and ext_flag stay set until a control-register write clears them. Further counting does not clear them.
- R7: With ext_en=1 and cap_mode=1, a falling edge on `ext_pin` copies the count into the reload registers and sets ext_flag, and the count keeps running. With ext_en=0 the edge changes nothing.
- R8: With ext_en=1 and cap_mode=0, a falling edge on `ext_pin` loads the reload value into the count and sets ext_flag.
- R9: With updown_en=1, `ext_pin` high counts up and low counts down. Counting down from a count equal to the reload value gives FFFFh. Counting up from FFFFh gives the reload value. Each such wrap sets ovf_flag and toggles ext_flag. Edges on `ext_pin` cause neither capture nor reload.
- R10: While rx_sel or tx_sel is 1, an overflow reloads the count and does not set ovf_flag. Each overflow drives a one-cycle pulse on `rx_baud_pulse` if rx_sel=1, and on `tx_baud_pulse` if tx_sel=1.
- R11: With pin_out_en=1, each overflow toggles `clk_out`.
- R12: `irq` is high when ovf_flag=1, or when ext_flag=1 and updown_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register select for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per byte written |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_in | input | 1 | Timer-mode count enable (prescaled tick) |
| count_pin | input | 1 | External event pin, counts on falling edges |
| ext_pin | input | 1 | Trigger pin: capture/reload edge or up/down direction |
| irq | output | 1 | Interrupt request |
| rx_baud_pulse | output | 1 | Overflow pulse for the receive baud clock |
| tx_baud_pulse | output | 1 | Overflow pulse for the transmit baud clock |
| clk_out | output | 1 | Toggles on every overflow when enabled |

## Verification
Assertions check on every cycle that a stopped, unwritten count stays frozen, and that an up overflow or a down wrap loads the reload value or FFFFh. They also check that baud selection keeps ovf_flag from rising, that the flags remain sticky without a control write, that a capture sets ext_flag, that `clk_out` changes only on an overflow, and that each baud pulse follows its select bit. The bench's directed scenarios cover the rest. They set the actual count and reload values through each mode: capture against reload, ignored trigger edges, direction changes through the synchronizer, the interrupt masking in up/down mode, and the exact number of baud pulses and output toggles over a run of overflows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam int A_CNT_LO = 0;
  localparam int A_CNT_HI = 1;
  localparam int A_RLD_LO = 2;
  localparam int A_RLD_HI = 3;
  localparam int A_CTRL   = 4;
  localparam int A_MODE   = 5;

  // packed MSB first: ovf_flag is bit 7, cap_mode is bit 0
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic src_ext;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_src_i,
  input  logic             updown_i,
  input  logic             dir_up_i,
  input  logic             baud_i,
  input  logic             cap_mode_i,
  input  logic             ext_evt_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             cap_evt_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic step, going_down, ext_reload, reload_on_wrap, plain_trig;

  assign step           = run_i & step_src_i;
  assign going_down     = updown_i & ~dir_up_i;
  assign plain_trig     = ext_evt_i & ~updown_i & ~baud_i;
  assign ext_reload     = plain_trig & ~cap_mode_i;
  assign cap_evt_o      = plain_trig & cap_mode_i;
  assign reload_on_wrap = updown_i | baud_i | ~cap_mode_i;
  assign wrap_o         = step & (going_down ? (cnt_q == rld_i) : (cnt_q == MAXV));

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[BYTE_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:BYTE_W] = wdata_i;
    end else if (ext_reload) begin
      cnt_d = rld_i;
    end else if (wrap_o) begin
      if (going_down)          cnt_d = MAXV;
      else if (reload_on_wrap) cnt_d = rld_i;
      else                     cnt_d = '0;
    end else if (step) begin
      cnt_d = going_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: stopped and unwritten count does not move
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_lo_i && !wr_hi_i && !ext_reload) |=> $stable(cnt_q));
  // R5: up overflow in reload/baud/updown modes lands on the reload value
  a_r5_up_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !going_down && reload_on_wrap && !wr_lo_i && !wr_hi_i && !ext_reload)
      |=> cnt_q == $past(rld_i));
  // R9: down wrap lands on all ones
  a_r9_down_wrap_max: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && going_down && !wr_lo_i && !wr_hi_i) |=> cnt_q == MAXV);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  input  logic              cap_evt_i,
  input  logic              ext_evt_i,
  output ctrl_t             ctrl_o,
  output logic              updown_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              irq_o,
  output logic              rx_pulse_o,
  output logic              tx_pulse_o,
  output logic              clkout_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] rld_q;
  logic             rx_q, tx_q, clkout_q;
  logic             ctrl_wr, baud;

  assign ctrl_wr = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign baud    = ctrl_q.rx_sel | ctrl_q.tx_sel;

  always_comb begin
    ctrl_d = ctrl_wr ? ctrl_t'(wdata_i) : ctrl_q;
    if (wrap_i && !baud)            ctrl_d.ovf = 1'b1;
    if (ext_evt_i && !mode_q[0])    ctrl_d.ext = 1'b1;
    if (wrap_i && mode_q[0])        ctrl_d.ext = ~ctrl_d.ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      rld_q    <= '0;
      rx_q     <= 1'b0;
      tx_q     <= 1'b0;
      clkout_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_i && addr_i == ADDR_W'(A_MODE)) mode_q <= wdata_i[1:0];
      if (cap_evt_i) begin
        rld_q <= cnt_i;
      end else if (wr_i) begin
        if (addr_i == ADDR_W'(A_RLD_LO)) rld_q[BYTE_W-1:0]     <= wdata_i;
        if (addr_i == ADDR_W'(A_RLD_HI)) rld_q[CNT_W-1:BYTE_W] <= wdata_i;
      end
      rx_q <= wrap_i & ctrl_q.rx_sel;
      tx_q <= wrap_i & ctrl_q.tx_sel;
      if (wrap_i && mode_q[1]) clkout_q <= ~clkout_q;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_CNT_LO): rdata_o = cnt_i[BYTE_W-1:0];
      ADDR_W'(A_CNT_HI): rdata_o = cnt_i[CNT_W-1:BYTE_W];
      ADDR_W'(A_RLD_LO): rdata_o = rld_q[BYTE_W-1:0];
      ADDR_W'(A_RLD_HI): rdata_o = rld_q[CNT_W-1:BYTE_W];
      ADDR_W'(A_CTRL):   rdata_o = ctrl_q;
      ADDR_W'(A_MODE):   rdata_o = {{(BYTE_W-2){1'b0}}, mode_q};
      default:           rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign updown_o   = mode_q[0];
  assign rld_o      = rld_q;
  assign irq_o      = ctrl_q.ovf | (ctrl_q.ext & ~mode_q[0]);
  assign rx_pulse_o = rx_q;
  assign tx_pulse_o = tx_q;
  assign clkout_o   = clkout_q;

  // R10: baud selection keeps the overflow flag from rising
  a_r10_no_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_wr) |=> !$rose(ctrl_q.ovf));
  // R10: a receive pulse only follows a cycle with receive selected
  a_r10_rx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q |-> $past(ctrl_q.rx_sel));
  // R6: flags are sticky without a control write
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf && !ctrl_wr) |=> ctrl_q.ovf);
  // R7: a capture sets the trigger flag
  a_r7_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_i |=> ctrl_q.ext);
  // R11: the output pin moves only on an overflow
  a_r11_clkout_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(clkout_q));
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tick_in,
  input  logic              count_pin,
  input  logic              ext_pin,
  output logic              irq,
  output logic              rx_baud_pulse,
  output logic              tx_baud_pulse,
  output logic              clk_out
);
  localparam int NPINS = 2;  // index 0: count pin, index 1: trigger pin

  logic [NPINS-1:0] pins, lvl, fall;
  assign pins = {ext_pin, count_pin};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pins[g]),
      .level_o(lvl[g]), .fall_o(fall[g])
    );
  end

  ctrl_t            ctrl;
  logic             updown, wrap, cap_evt, ext_evt, step_src;
  logic [CNT_W-1:0] cnt, rld;

  assign step_src = ctrl.src_ext ? fall[0] : tick_in;
  assign ext_evt  = fall[1] & ctrl.ext_en;

  tmr_count u_count (
    .clk(clk), .rst_n(rst_n),
    .run_i(ctrl.run), .step_src_i(step_src),
    .updown_i(updown), .dir_up_i(lvl[1]),
    .baud_i(ctrl.rx_sel | ctrl.tx_sel), .cap_mode_i(ctrl.cap_mode),
    .ext_evt_i(ext_evt),
    .wr_lo_i(reg_wr && reg_addr == ADDR_W'(A_CNT_LO)),
    .wr_hi_i(reg_wr && reg_addr == ADDR_W'(A_CNT_HI)),
    .wdata_i(reg_wdata), .rld_i(rld),
    .cnt_o(cnt), .wrap_o(wrap), .cap_evt_o(cap_evt)
  );

  tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .addr_i(reg_addr), .wr_i(reg_wr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .cnt_i(cnt), .wrap_i(wrap), .cap_evt_i(cap_evt), .ext_evt_i(ext_evt),
    .ctrl_o(ctrl), .updown_o(updown), .rld_o(rld),
    .irq_o(irq), .rx_pulse_o(rx_baud_pulse), .tx_pulse_o(tx_baud_pulse),
    .clkout_o(clk_out)
  );
endmodule

// File: tb/cr_timer16_test.sv
module cr_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_in = 1'b0, count_pin = 1'b1, ext_pin = 1'b1;
  logic       irq, rx_baud_pulse, tx_baud_pulse, clk_out;

  int checks = 0, fails = 0, rx_n = 0, tx_n = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cr_timer16 uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_in(tick_in),
    .count_pin(count_pin), .ext_pin(ext_pin), .irq(irq),
    .rx_baud_pulse(rx_baud_pulse), .tx_baud_pulse(tx_baud_pulse), .clk_out(clk_out)
  );

  always @(posedge clk) begin
    if (rx_baud_pulse) rx_n <= rx_n + 1;
    if (tx_baud_pulse) tx_n <= tx_n + 1;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reg reset", {8'h0, d}, 16'h0000);
    end
    chk("R1 irq reset", {15'h0, irq}, 16'h0);
    chk("R1 clk_out reset", {15'h0, clk_out}, 16'h0);
    chk("R1 baud pulses reset", {14'h0, rx_baud_pulse, tx_baud_pulse}, 16'h0);
  endtask

  task automatic t_regmap();
    logic [15:0] v; logic [7:0] d;
    wr16(3'd2, 16'h55AA); rd16(3'd2, v); chk("R2 reload readback", v, 16'h55AA);
    wr(3'd5, 8'hFF); rd(3'd5, d); chk("R2 mode upper bits zero", {8'h0, d}, 16'h0003);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    wr16(3'd0, 16'h00F0); wr(3'd4, 8'h04); ticks(5); wr(3'd4, 8'h00);
    rd16(3'd0, v); chk("R3 tick counting", v, 16'h00F5);
    ticks(3); rd16(3'd0, v); chk("R3 hold when stopped", v, 16'h00F5);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    wr16(3'd0, 16'h0000); wr(3'd4, 8'h06); ticks(4);
    rd16(3'd0, v); chk("R4 tick ignored in pin mode", v, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      count_pin = 1'b0; settle(); count_pin = 1'b1; settle();
    end
    rd16(3'd0, v); chk("R4 pin edges counted", v, 16'h0003);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_overflow();
    logic [15:0] v; logic [7:0] d;
    wr16(3'd2, 16'h1234); wr16(3'd0, 16'hFFFE); wr(3'd4, 8'h05); ticks(2);
    rd16(3'd0, v); chk("R5 capture-mode overflow to zero", v, 16'h0000);
    rd(3'd4, d); chk("R5 ovf flag set", {8'h0, d}, 16'h0085);
    chk("R12 irq from ovf", {15'h0, irq}, 16'h1);
    ticks(1); rd(3'd4, d); chk("R6 flag stays set", {8'h0, d}, 16'h0085);
    wr(3'd4, 8'h00); rd(3'd4, d); chk("R6 flag cleared by write", {8'h0, d}, 16'h0000);
    chk("R12 irq cleared", {15'h0, irq}, 16'h0);
    wr16(3'd0, 16'hFFFF); wr(3'd4, 8'h04); ticks(1);
    rd16(3'd0, v); chk("R5 reload-mode overflow", v, 16'h1234);
    rd(3'd4, d); chk("R5 ovf flag in reload mode", {8'h0, d}, 16'h0084);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_capture();
    logic [15:0] v; logic [7:0] d;
    wr16(3'd0, 16'h0300); wr(3'd4, 8'h0D); ticks(2);
    ext_pin = 1'b0; settle();
    rd16(3'd2, v); chk("R7 captured value", v, 16'h0302);
    rd(3'd4, d); chk("R7 ext flag set", {8'h0, d}, 16'h004D);
    chk("R12 irq from ext flag", {15'h0, irq}, 16'h1);
    ticks(1); rd16(3'd0, v); chk("R7 count keeps running", v, 16'h0303);
    wr(3'd4, 8'h05); ext_pin = 1'b1; settle(); ext_pin = 1'b0; settle();
    rd16(3'd2, v); chk("R7 edge ignored without ext_en", v, 16'h0302);
    rd(3'd4, d); chk("R7 no flag without ext_en", {8'h0, d}, 16'h0005);
    ext_pin = 1'b1; settle(); wr(3'd4, 8'h00);
  endtask

  task automatic t_reload_edge();
    logic [15:0] v; logic [7:0] d;
    wr16(3'd0, 16'h0100); wr16(3'd2, 16'h2222); wr(3'd4, 8'h08);
    ext_pin = 1'b0; settle();
    rd16(3'd0, v); chk("R8 edge reload", v, 16'h2222);
    rd(3'd4, d); chk("R8 ext flag set", {8'h0, d}, 16'h0048);
    ext_pin = 1'b1; settle(); wr(3'd4, 8'h00);
  endtask

  task automatic t_updown();
    logic [15:0] v; logic [7:0] d;
    wr(3'd5, 8'h01); wr16(3'd2, 16'h0010); wr16(3'd0, 16'h0011);
    ext_pin = 1'b0; settle(); wr(3'd4, 8'h04);
    ticks(1); rd16(3'd0, v); chk("R9 count down", v, 16'h0010);
    ticks(1); rd16(3'd0, v); chk("R9 down wrap to FFFF", v, 16'hFFFF);
    rd(3'd4, d); chk("R9 flags on down wrap", {8'h0, d}, 16'h00C4);
    wr(3'd4, 8'h44);
    chk("R12 ext flag masked in updown", {15'h0, irq}, 16'h0);
    ext_pin = 1'b1; settle();
    ticks(1); rd16(3'd0, v); chk("R9 up wrap to reload", v, 16'h0010);
    rd(3'd4, d); chk("R9 ext flag toggles back", {8'h0, d}, 16'h0084);
    ticks(1); wr(3'd4, 8'h0D); ext_pin = 1'b0; settle();
    rd16(3'd2, v); chk("R9 no capture in updown", v, 16'h0010);
    rd(3'd4, d); chk("R9 no flag from edge in updown", {8'h0, d}, 16'h000D);
    rd16(3'd0, v); chk("R9 count untouched by edge", v, 16'h0011);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); ext_pin = 1'b1; settle();
  endtask

  task automatic t_baud();
    logic [15:0] v; logic [7:0] d;
    wr(3'd5, 8'h02); wr16(3'd2, 16'hFFFE); wr16(3'd0, 16'hFFFF);
    rx_n = 0; tx_n = 0; wr(3'd4, 8'h24);
    ticks(1);
    chk("R11 clk_out toggled once", {15'h0, clk_out}, 16'h1);
    rd16(3'd0, v); chk("R10 baud overflow reloads", v, 16'hFFFE);
    ticks(2);
    chk("R10 rx pulse count", rx_n[15:0], 16'd2);
    chk("R10 no tx pulse", tx_n[15:0], 16'd0);
    chk("R11 clk_out toggled twice", {15'h0, clk_out}, 16'h0);
    rd(3'd4, d); chk("R10 ovf flag suppressed", {8'h0, d}, 16'h0024);
    chk("R12 no irq in baud", {15'h0, irq}, 16'h0);
    wr(3'd4, 8'h14); ticks(2);
    chk("R10 tx pulse count", tx_n[15:0], 16'd1);
    chk("R10 rx unchanged", rx_n[15:0], 16'd2);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_regmap();
    t_timer();
    t_counter();
    t_overflow();
    t_capture();
    t_reload_edge();
    t_updown();
    t_baud();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule